// File: doc/BRIEF.md
# Open-Row DRAM Bank Command Sequencer

This block turns read requests for one row/column-organised DRAM bank into a timed stream of bank commands. It remembers which row the bank currently holds open. Each accepted request falls into one of three cases: the target row is already open (hit), no row is open (empty), or some other row is open (miss). For each case the block emits the command chain that the case needs, and it spaces every command by the minimum gap for that step.

The latency settings are sampled when a request is accepted. These settings are the read-to-data delay, the activate-to-read gap, the close-to-activate gap and the minimum open time of a row. A single-cycle or double-cycle command mode is sampled at the same moment. Once the read has been issued, a one-cycle data-valid strobe rises in the exact cycle the first data word would come back, and it carries the tag of the request. Only one request is in flight at any time. The block is intended to sit between a request source and the command pins of a bank model or a physical interface.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset no row is open, `req_ready` is high, `cmd_o` is NOP, `cmd_addr` is zero and `rd_valid` is low, so the first request is served as the empty case.
- R2: Hit case (requested row equals the open row): the only command is READ. Its first cycle comes two cycles after the accepting edge's cycle, that is, in cycle a+2 when the request is accepted at the end of cycle a.
- R3: Empty case: ACTIVATE starts in cycle a+2, and READ starts tRCD cycles after the last cycle of ACTIVATE. The row is then recorded as open.
- R4: Miss case: PRECHARGE (address = the row being closed) comes first. ACTIVATE starts tRP cycles after the last PRECHARGE cycle, and READ starts tRCD cycles after the last ACTIVATE cycle.
- R5: The first cycle of a PRECHARGE never comes earlier than tRAS cycles after the last cycle of the ACTIVATE that opened the row. Here tRAS is the value sampled with the request that issued that ACTIVATE. If the window has not yet passed, the PRECHARGE starts in the first cycle that meets it.
- R6: With the double-cycle mode selected, each command is driven for two consecutive cycles and every gap is measured from the second of them. With single-cycle mode, each command lasts one cycle.
- R7: `req_ready` is low from the cycle after an accepting edge up to and including the cycle before `rd_valid`. It is high again in the `rd_valid` cycle.
- R8: Command encoding is NOP=0, ACTIVATE=1, PRECHARGE=2, READ=3. `cmd_addr` carries the row (zero-extended) with ACTIVATE and PRECHARGE, the column (zero-extended) with READ, and zero with NOP.
- R9: `rd_valid` is high for exactly one cycle, CL cycles after the last READ cycle, and `rd_tag` then equals the accepted request's tag.
- R10: The timing and mode inputs are sampled only at the accepting edge; later changes do not affect the sequence in progress. A timing value of zero acts as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| req_tag | input | TAG_W | Request identifier returned with data-valid |
| cfg_cl | input | TW | Read-to-first-data delay in cycles |
| cfg_trcd | input | TW | Activate-to-read gap |
| cfg_trp | input | TW | Precharge-to-activate gap |
| cfg_tras | input | TW | Minimum activate-to-precharge time |
| cfg_cmd2t | input | 1 | 1 selects double-cycle commands |
| cmd_o | output | 2 | Bank command (NOP/ACT/PRE/READ) |
| cmd_addr | output | ADDR_W | Row or column address for the command |
| rd_valid | output | 1 | First read data returns this cycle |
| rd_tag | output | TAG_W | Tag of the request whose data returns |

## Verification
The assertions assume only one thing about the inputs: the reset is asserted at the start. The tRAS property trusts the minimum open time that the block latched with the request that activated the row. Every other property watches the command and handshake ports alone, and these hold for any values on the request and timing inputs. The stimulus keeps each request's timing inputs stable until the accepting edge. Right after that edge it overwrites them with random values, to show that the sequence in flight ignores them. Row numbers are drawn from a small set so that hits, misses and back-to-back tRAS stalls all occur often.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_PRE = 2'd2,
        CMD_RD  = 2'd3
    } dbs_cmd_e;

    typedef enum logic [1:0] {
        KIND_HIT   = 2'd0,
        KIND_EMPTY = 2'd1,
        KIND_MISS  = 2'd2
    } dbs_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_HOLD = 2'd2,
        ST_DATA = 2'd3
    } dbs_state_e;

    // A programmed delay of zero is served as one cycle.
    function automatic logic [31:0] floor_one(input logic [31:0] v);
        return (v == 32'd0) ? 32'd1 : v;
    endfunction

endpackage

// File: rtl/dbs_countdown.sv
module dbs_countdown #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         is_zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/dbs_row_track.sv
module dbs_row_track
    import dbs_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_set,
    input  logic             open_clr,
    input  logic [ROW_W-1:0] set_row,
    input  logic [ROW_W-1:0] probe_row,
    output logic [ROW_W-1:0] open_row,
    output dbs_kind_e        kind
);
    logic             open_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (open_set) begin
            open_q <= 1'b1;
            row_q  <= set_row;
        end else if (open_clr) begin
            open_q <= 1'b0;
        end
    end

    always_comb begin
        if (!open_q)                 kind = KIND_EMPTY;
        else if (row_q == probe_row) kind = KIND_HIT;
        else                         kind = KIND_MISS;
    end

    assign open_row = row_q;
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
    import dbs_pkg::*;
#(
    parameter int ROW_W  = 14,
    parameter int COL_W  = 10,
    parameter int TAG_W  = 4,
    parameter int TW     = 6,
    parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [TW-1:0]     cfg_cl,
    input  logic [TW-1:0]     cfg_trcd,
    input  logic [TW-1:0]     cfg_trp,
    input  logic [TW-1:0]     cfg_tras,
    input  logic              cfg_cmd2t,
    output logic [1:0]        cmd_o,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag
);
    dbs_state_e        state_q, state_d;
    dbs_cmd_e          cmd_q, cmd_d, nxt_cmd, fin_cmd;
    dbs_kind_e         kind;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              dv_q, dv_d;

    logic [ROW_W-1:0]  lat_row_q, pre_row_q, open_row;
    logic [COL_W-1:0]  lat_col_q;
    logic [TAG_W-1:0]  lat_tag_q, rd_tag_q;
    logic [TW-1:0]     lat_cl_q, lat_rcd_q, lat_rp_q, lat_ras_q;
    logic              lat_2t_q, pend_pre_q, pend_act_q;

    logic              accept, can_go, issue, fin;
    logic              gap_load, gap_zero, ras_load, ras_zero;
    logic [TW-1:0]     gap_val, fin_gap;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Command the pending chain needs next: close, then open, then read.
    always_comb begin
        if (pend_pre_q)      nxt_cmd = CMD_PRE;
        else if (pend_act_q) nxt_cmd = CMD_ACT;
        else                 nxt_cmd = CMD_RD;
    end

    assign can_go = gap_zero && (!pend_pre_q || ras_zero);
    assign issue  = (state_q == ST_WAIT) && can_go;

    // A command step ends on its last driven cycle's preceding edge.
    assign fin     = (issue && !lat_2t_q) || (state_q == ST_HOLD);
    assign fin_cmd = (state_q == ST_HOLD) ? cmd_q : nxt_cmd;

    always_comb begin
        unique case (fin_cmd)
            CMD_PRE: fin_gap = lat_rp_q;
            CMD_ACT: fin_gap = lat_rcd_q;
            default: fin_gap = lat_cl_q;
        endcase
    end

    always_comb begin
        state_d  = state_q;
        cmd_d    = CMD_NOP;
        addr_d   = '0;
        dv_d     = 1'b0;
        gap_load = 1'b0;
        gap_val  = '0;
        ras_load = 1'b0;

        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d  = ST_WAIT;
                    gap_load = 1'b1;
                end
            end
            ST_WAIT: begin
                if (issue) begin
                    cmd_d = nxt_cmd;
                    unique case (nxt_cmd)
                        CMD_PRE: addr_d = ADDR_W'(pre_row_q);
                        CMD_ACT: addr_d = ADDR_W'(lat_row_q);
                        default: addr_d = ADDR_W'(lat_col_q);
                    endcase
                    if (lat_2t_q) state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                cmd_d  = cmd_q;
                addr_d = addr_q;
            end
            ST_DATA: begin
                if (gap_zero) begin
                    dv_d    = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase

        if (fin) begin
            gap_load = 1'b1;
            gap_val  = fin_gap - TW'(1);
            ras_load = (fin_cmd == CMD_ACT);
            state_d  = (fin_cmd == CMD_RD) ? ST_DATA : ST_WAIT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cmd_q      <= CMD_NOP;
            addr_q     <= '0;
            dv_q       <= 1'b0;
            rd_tag_q   <= '0;
            lat_row_q  <= '0;
            pre_row_q  <= '0;
            lat_col_q  <= '0;
            lat_tag_q  <= '0;
            lat_cl_q   <= TW'(1);
            lat_rcd_q  <= TW'(1);
            lat_rp_q   <= TW'(1);
            lat_ras_q  <= TW'(1);
            lat_2t_q   <= 1'b0;
            pend_pre_q <= 1'b0;
            pend_act_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
            addr_q  <= addr_d;
            dv_q    <= dv_d;
            if (dv_d) rd_tag_q <= lat_tag_q;
            if (accept) begin
                lat_row_q  <= req_row;
                pre_row_q  <= open_row;
                lat_col_q  <= req_col;
                lat_tag_q  <= req_tag;
                lat_cl_q   <= TW'(floor_one(32'(cfg_cl)));
                lat_rcd_q  <= TW'(floor_one(32'(cfg_trcd)));
                lat_rp_q   <= TW'(floor_one(32'(cfg_trp)));
                lat_ras_q  <= TW'(floor_one(32'(cfg_tras)));
                lat_2t_q   <= cfg_cmd2t;
                pend_pre_q <= (kind == KIND_MISS);
                pend_act_q <= (kind != KIND_HIT);
            end else if (issue) begin
                if (nxt_cmd == CMD_PRE)      pend_pre_q <= 1'b0;
                else if (nxt_cmd == CMD_ACT) pend_act_q <= 1'b0;
            end
        end
    end

    dbs_row_track #(.ROW_W(ROW_W)) track_i (
        .clk       (clk),
        .rst       (rst),
        .open_set  (issue && (nxt_cmd == CMD_ACT)),
        .open_clr  (issue && (nxt_cmd == CMD_PRE)),
        .set_row   (lat_row_q),
        .probe_row (req_row),
        .open_row  (open_row),
        .kind      (kind)
    );

    // Step spacing and read-to-data delay share one counter.
    dbs_countdown #(.W(TW)) gap_i (
        .clk      (clk),
        .rst      (rst),
        .load     (gap_load),
        .load_val (gap_val),
        .is_zero  (gap_zero)
    );

    // Minimum open time of the current row before it may be closed.
    dbs_countdown #(.W(TW)) ras_i (
        .clk      (clk),
        .rst      (rst),
        .load     (ras_load),
        .load_val (lat_ras_q - TW'(1)),
        .is_zero  (ras_zero)
    );

    assign cmd_o    = cmd_q;
    assign cmd_addr = addr_q;
    assign rd_valid = dv_q;
    assign rd_tag   = rd_tag_q;
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker
    import dbs_pkg::*;
#(
    parameter int TW     = 6,
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        cmd,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_valid,
    input logic              two_t,
    input logic [TW-1:0]     act_ras
);
    logic [TW+1:0] since_act_q;
    logic [TW-1:0] need_q;
    logic          seen_act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act_q <= '0;
            need_q      <= '0;
            seen_act_q  <= 1'b0;
        end else if (cmd == CMD_ACT) begin
            since_act_q <= (TW+2)'(1);
            need_q      <= act_ras;
            seen_act_q  <= 1'b1;
        end else if (since_act_q != '1) begin
            since_act_q <= since_act_q + (TW+2)'(1);
        end
    end

    // R5: a close starts only after the open window has run out
    a_r5_pre_after_ras: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE && $past(cmd) != CMD_PRE && seen_act_q)
            |-> (since_act_q >= (TW+2)'(need_q)));

    // R6: in double-cycle mode a new command is repeated once
    a_r6_two_cycle_hold: assert property (@(posedge clk) disable iff (rst)
        (two_t && cmd != CMD_NOP && cmd != $past(cmd)) |=> (cmd == $past(cmd)));

    // R7: no request is taken while commands are on the bus
    a_r7_busy_on_cmd: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_NOP) |-> !req_ready);

    // R7: an accepted request drops ready on the next cycle
    a_r7_accept_drops_ready: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R8: idle command slots carry no address
    a_r8_nop_addr_zero: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_NOP) |-> (addr == '0));

    // R9: data-valid is a single-cycle pulse
    a_r9_dv_single: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
endmodule

bind dram_bank_seq dbs_checker #(.TW(TW), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cmd       (cmd_o),
    .addr      (cmd_addr),
    .rd_valid  (rd_valid),
    .two_t     (lat_2t_q),
    .act_ras   (lat_ras_q)
);

// File: tb/dram_bank_seq_tb_top.sv
module dram_bank_seq_tb_top;
    localparam int ROW_W  = 14;
    localparam int COL_W  = 10;
    localparam int TAG_W  = 4;
    localparam int TW     = 6;
    localparam int ADDR_W = 14;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic [TW-1:0]     cfg_cl = '0, cfg_trcd = '0, cfg_trp = '0, cfg_tras = '0;
    logic              cfg_cmd2t = 1'b0;
    logic [1:0]        cmd_o;
    logic [ADDR_W-1:0] cmd_addr;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state of the bank
    bit m_open = 0;
    int m_row = 0;
    int m_act_last = -100000;
    int m_ras = 1;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_bank_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W), .TW(TW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .req_col(req_col), .req_tag(req_tag),
        .cfg_cl(cfg_cl), .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp), .cfg_tras(cfg_tras),
        .cfg_cmd2t(cfg_cmd2t), .cmd_o(cmd_o), .cmd_addr(cmd_addr),
        .rd_valid(rd_valid), .rd_tag(rd_tag)
    );

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic do_req(input int row, input int col, input int tag,
                          input int cl, input int rcd, input int rp, input int ras,
                          input bit t2, input int idle);
        int a, h, t, pre_f, pre_l, act_f, act_l, rd_f, rd_l, dv, kind, wait_n;
        int e_cmd, e_addr, bad_cmd_a, bad_cmd_e, bad_addr_a, bad_addr_e;
        bit seq_bad, addr_bad, rdy_bad, dv_bad, ras_bound;
        string stag;
        repeat (idle) @(negedge clk);
        req_row = ROW_W'(row); req_col = COL_W'(col); req_tag = TAG_W'(tag);
        cfg_cl = TW'(cl); cfg_trcd = TW'(rcd); cfg_trp = TW'(rp); cfg_tras = TW'(ras);
        cfg_cmd2t = t2;
        wait_n = 0;
        while (!req_ready && wait_n < 1000) begin
            @(negedge clk);
            wait_n++;
        end
        chk(req_ready, "R7 ready before request", 0, 1);
        req_valid = 1'b1;
        a = cyc;
        // expected schedule from the requirements
        h = t2 ? 1 : 0;
        kind = !m_open ? 1 : ((m_row == row) ? 0 : 2);
        pre_f = -1; pre_l = -1; act_f = -1; act_l = -1;
        t = a + 2;
        ras_bound = 0;
        if (kind == 2) begin
            pre_f = t;
            if (m_act_last + m_ras > pre_f) begin
                pre_f = m_act_last + m_ras;
                ras_bound = 1;
            end
            pre_l = pre_f + h;
            t = pre_l + eff(rp);
        end
        if (kind != 0) begin
            act_f = t; act_l = act_f + h;
            t = act_l + eff(rcd);
        end
        rd_f = t; rd_l = rd_f + h;
        dv = rd_l + eff(cl);
        stag = (kind == 0) ? "R2" : ((kind == 1) ? "R3" : "R4");
        if (t2) stag = {stag, " R6"};
        stag = {stag, " R10"};

        @(negedge clk);
        req_valid = 1'b0;
        // R10: later input changes must not disturb the sequence
        cfg_cl = TW'($urandom); cfg_trcd = TW'($urandom); cfg_trp = TW'($urandom);
        cfg_tras = TW'($urandom); cfg_cmd2t = 1'($urandom);
        req_row = ROW_W'($urandom); req_col = COL_W'($urandom);

        seq_bad = 0; addr_bad = 0; rdy_bad = 0; dv_bad = 0;
        bad_cmd_a = 0; bad_cmd_e = 0; bad_addr_a = 0; bad_addr_e = 0;
        for (int c = a + 1; c <= dv; c++) begin
            if (c != a + 1) @(negedge clk);
            e_cmd = 0; e_addr = 0;
            if (c >= pre_f && c <= pre_l)      begin e_cmd = 2; e_addr = m_row; end
            else if (c >= act_f && c <= act_l) begin e_cmd = 1; e_addr = row; end
            else if (c >= rd_f && c <= rd_l)   begin e_cmd = 3; e_addr = col; end
            if (int'(cmd_o) != e_cmd && !seq_bad) begin
                seq_bad = 1; bad_cmd_a = int'(cmd_o); bad_cmd_e = e_cmd;
            end
            if (int'(cmd_addr) != e_addr && !addr_bad) begin
                addr_bad = 1; bad_addr_a = int'(cmd_addr); bad_addr_e = e_addr;
            end
            if (req_ready != (c == dv)) rdy_bad = 1;
            if (rd_valid != (c == dv)) dv_bad = 1;
            if (c == dv) chk(int'(rd_tag) == tag, "R9 tag", int'(rd_tag), tag);
        end
        chk(!seq_bad, stag, bad_cmd_a, bad_cmd_e);
        if (ras_bound) chk(!seq_bad, "R5 precharge wait", bad_cmd_a, bad_cmd_e);
        chk(!addr_bad, "R8 address", bad_addr_a, bad_addr_e);
        chk(!rdy_bad, "R7 ready window", int'(req_ready), 1);
        chk(!dv_bad, "R9 data-valid timing", int'(rd_valid), 1);
        if (kind != 0) begin
            m_act_last = act_l;
            m_ras = eff(ras);
        end
        m_open = 1;
        m_row = row;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle state after reset
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(cmd_o == 2'd0, "R1 command", int'(cmd_o), 0);
        chk(cmd_addr == '0, "R1 address", int'(cmd_addr), 0);
        chk(rd_valid == 1'b0, "R1 data-valid", int'(rd_valid), 0);

        // directed: empty, hit, miss, tRAS stall, zero timings, double-cycle mode
        do_req(5, 9, 1, 4, 3, 2, 6, 0, 0);     // R1 R3 empty after reset
        do_req(5, 17, 2, 3, 2, 2, 6, 0, 0);    // R2 hit
        do_req(7, 33, 3, 2, 3, 2, 30, 0, 0);   // R4 miss, opens with long window
        do_req(2, 44, 4, 2, 2, 3, 4, 0, 0);    // R5 miss stalls on window
        do_req(3, 1, 5, 0, 0, 0, 0, 0, 0);     // R10 zero timings
        do_req(3, 2, 6, 0, 0, 0, 0, 0, 0);     // R10 hit with CL of zero
        do_req(3, 5, 7, 3, 1, 1, 2, 1, 0);     // R6 hit in double-cycle mode
        do_req(9, 6, 8, 2, 3, 2, 20, 1, 1);    // R6 miss in double-cycle mode
        do_req(1, 7, 9, 1, 1, 1, 1, 1, 0);     // R5 R6 miss waiting on window

        for (int i = 0; i < 80; i++) begin
            do_req(int'($urandom % 4), int'($urandom % 1024), int'($urandom % 16),
                   int'($urandom % 8), int'($urandom % 8), int'($urandom % 8),
                   int'($urandom % 25), 1'($urandom), int'($urandom % 3));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule